// File: doc/BRIEF.md
# DRAM Clock-Enable Power-Down Controller

This block drives the two clock-enable (CKE) pins of one DRAM channel. It watches per-chip-select activity: a pending-transaction flag and an all-banks-closed flag for each chip select. When the chip selects behind a CKE pin have no work and no open page for long enough, the block lowers that pin to put the devices into power-down. As soon as work arrives for any of those chip selects, it raises the pin again. A per-pin ready output then stays low for a programmable exit latency before the command scheduler may address that group.

Two granularities are supported. In whole-channel mode both pins move together and follow the idleness of every chip select on the channel. In chip-select mode the lower half of the chip selects is tied to CKE pin 0 and the upper half to CKE pin 1, and each pin follows its own half. A power-down enable input gates entry. The mode input is taken into account only while both pins are high. Idle qualification and exit latency are programmable cycle counts.

Top module: `cke_pd_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the block takes its reset state: cke = 2'b11, pd_state = 2'b00, ready = 2'b11, and the latched mode is whole-channel (code 0).
- R2: In chip-select mode (mode code 1), chip selects 0 to NUM_CS/2-1 govern cke[0] and chip selects NUM_CS/2 to NUM_CS-1 govern cke[1]. Activity in one half never wakes or holds up the other pin.
- R3: A pin counts as quiet only when pd_en is 1, no covered chip select has its pending flag set, and every covered chip select reports all banks closed. A pin that is not quiet never drops.
- R4: In whole-channel mode (code 0), both pins cover all chip selects, so cke[0] always equals cke[1].
- R5: With idle_limit = L, a high pin drops on the clock edge that samples its (L+1)th consecutive quiet cycle. With L = 0 it drops on the first quiet edge.
- R6: A low pin rises on the first clock edge at which it is not quiet.
- R7: With exit_lat = E loaded at the rising edge of a pin, its ready output is low while the pin is low, stays low for E cycles after the pin rises, and goes high on the Eth edge after the rise (at once if E = 0).
- R8: pd_state[g] is 1 exactly when cke[g] is 0.
- R9: The latched mode takes the value of cs_mode only on edges at which both pins are high. Otherwise it holds its value.
- R10: An edge that loads a mode different from the latched one restarts the idle qualification of both pins. That edge does not count as a quiet cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_en | input | 1 | Power-down permitted |
| cs_mode | input | 1 | Requested granularity: 0 whole channel, 1 per chip-select half |
| cs_pending | input | NUM_CS | Transaction scheduled to chip select i |
| cs_closed | input | NUM_CS | All banks of chip select i are closed |
| idle_limit | input | IDLE_W | Extra quiet cycles required before a pin drops |
| exit_lat | input | XP_W | Cycles from a pin rising to its ready going high |
| cke | output | 2 | Clock-enable pins |
| pd_state | output | 2 | Pin g is in power-down |
| ready | output | 2 | Group g may accept commands |

## Verification
Every output comes from registers, so a change in the inputs set up before an edge appears on cke, pd_state and ready right after that edge. Entry comes idle_limit edges after the first quiet edge. Ready follows a rise by exit_lat edges. The bench drives inputs and compares outputs on the falling edge, half a cycle away from any update. A behavioural model advances on each rising edge from the same inputs, and all three outputs are compared with it every cycle. Scenario checks then confirm the expected pin pattern at points placed well past the computed entry and exit times.

// File: rtl/cke_pd_pkg.sv
// Shared types for the CKE power-down controller.
package cke_pd_pkg;
    typedef enum logic {
        PD_MODE_CHAN = 1'b0,   // both pins follow whole-channel idleness
        PD_MODE_CS   = 1'b1    // each pin follows its own chip-select half
    } pd_mode_e;
endpackage

// File: rtl/cke_quiet_map.sv
// Maps per-chip-select activity onto the quiet condition of each CKE pin.
// Assumes NUM_CS is even; the lower half belongs to pin 0, upper to pin 1.
module cke_quiet_map
    import cke_pd_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic              pd_en_i,
    input  pd_mode_e          mode_i,
    input  logic [NUM_CS-1:0] pending_i,
    input  logic [NUM_CS-1:0] closed_i,
    output logic [1:0]        quiet_o
);
    localparam int HALF = NUM_CS / 2;

    logic [1:0] grp_idle;
    logic       chan_idle;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_grp
            // Group idle: no pending work and every page closed in this half.
            always_comb begin
                grp_idle[g] = ~|pending_i[g*HALF +: HALF] & (&closed_i[g*HALF +: HALF]);
            end
            // Select the granularity and apply the power-down enable.
            always_comb begin
                quiet_o[g] = pd_en_i & ((mode_i == PD_MODE_CS) ? grp_idle[g] : chan_idle);
            end
        end
    endgenerate

    // Whole-channel idleness is the conjunction of both halves.
    always_comb chan_idle = &grp_idle;
endmodule

// File: rtl/cke_group.sv
// One CKE pin: qualifies idleness with a counter, drops the pin, wakes it
// on demand and holds ready low for the exit latency. Assumes the quiet
// input is already gated by the power-down enable.
module cke_group #(
    parameter int IDLE_W = 8,
    parameter int XP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              quiet_i,
    input  logic              clr_i,
    input  logic [IDLE_W-1:0] idle_lim_i,
    input  logic [XP_W-1:0]   exit_lat_i,
    output logic              cke_o,
    output logic              ready_o,
    output logic              pd_o
);
    logic              cke_q;
    logic [IDLE_W-1:0] idle_cnt;
    logic [XP_W-1:0]   xp_cnt;
    logic              drop;

    // Entry decision: pin high, no restart, quiet, qualification complete.
    always_comb drop = cke_q & ~clr_i & quiet_i & (idle_cnt >= idle_lim_i);

    // Pin state, idle qualification and exit-latency countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q    <= 1'b1;
            idle_cnt <= '0;
            xp_cnt   <= '0;
        end else if (cke_q) begin
            if (drop) begin
                cke_q    <= 1'b0;
                idle_cnt <= '0;
                xp_cnt   <= '0;
            end else begin
                if (clr_i || !quiet_i) idle_cnt <= '0;
                else                   idle_cnt <= idle_cnt + 1'b1;
                if (xp_cnt != '0)      xp_cnt   <= xp_cnt - 1'b1;
            end
        end else if (!quiet_i) begin
            cke_q    <= 1'b1;
            idle_cnt <= '0;
            xp_cnt   <= exit_lat_i;
        end
    end

    // Outputs: ready once the pin is up and the exit window has elapsed.
    always_comb begin
        cke_o   = cke_q;
        pd_o    = ~cke_q;
        ready_o = cke_q & (xp_cnt == '0);
    end

    // R3
    fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke_q) |-> $past(quiet_i));
    // R6
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_q && !quiet_i) |=> cke_q);
    // R7
    exit_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cke_q) && $past(exit_lat_i) != '0) |-> !ready_o);
endmodule

// File: rtl/cke_pd_ctrl.sv
// Top of the CKE power-down controller for one DRAM channel with two CKE
// pins. Latches the granularity only while both pins are up, derives the
// per-pin quiet condition and runs one pin controller per CKE.
module cke_pd_ctrl
    import cke_pd_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int IDLE_W = 8,
    parameter int XP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_en,
    input  logic              cs_mode,
    input  logic [NUM_CS-1:0] cs_pending,
    input  logic [NUM_CS-1:0] cs_closed,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic [XP_W-1:0]   exit_lat,
    output logic [1:0]        cke,
    output logic [1:0]        pd_state,
    output logic [1:0]        ready
);
    pd_mode_e   mode_q;
    pd_mode_e   mode_req;
    logic [1:0] quiet;
    logic       both_up;
    logic       mode_clr;

    // Decode the requested mode and detect a load that changes it.
    always_comb begin
        mode_req = pd_mode_e'(cs_mode);
        both_up  = &cke;
        mode_clr = both_up & (mode_req != mode_q);
    end

    // Mode latch: follows the request only while both pins are high.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= PD_MODE_CHAN;
        else if (both_up) mode_q <= mode_req;
    end

    cke_quiet_map #(.NUM_CS(NUM_CS)) u_map (
        .pd_en_i   (pd_en),
        .mode_i    (mode_q),
        .pending_i (cs_pending),
        .closed_i  (cs_closed),
        .quiet_o   (quiet)
    );

    generate
        for (genvar g = 0; g < 2; g++) begin : g_pin
            cke_group #(.IDLE_W(IDLE_W), .XP_W(XP_W)) u_grp (
                .clk        (clk),
                .rst_n      (rst_n),
                .quiet_i    (quiet[g]),
                .clr_i      (mode_clr),
                .idle_lim_i (idle_limit),
                .exit_lat_i (exit_lat),
                .cke_o      (cke[g]),
                .ready_o    (ready[g]),
                .pd_o       (pd_state[g])
            );
        end
    endgenerate

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cke[0] && cke[1]) |=> $stable(mode_q));
    // R4
    chan_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PD_MODE_CHAN) |-> (cke[0] == cke[1]));
endmodule

// File: tb/cke_pd_ctrl_bench.sv
`timescale 1ns/1ps
module cke_pd_ctrl_bench;
    localparam int NUM_CS = 4;
    localparam int IDLE_W = 8;
    localparam int XP_W   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_en = 1'b0;
    logic cs_mode = 1'b0;
    logic [NUM_CS-1:0] cs_pending = '1;
    logic [NUM_CS-1:0] cs_closed  = '0;
    logic [IDLE_W-1:0] idle_limit = '0;
    logic [XP_W-1:0]   exit_lat   = '0;
    logic [1:0] cke, pd_state, ready;

    int vectors = 0;
    int errors  = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    cke_pd_ctrl #(.NUM_CS(NUM_CS), .IDLE_W(IDLE_W), .XP_W(XP_W)) u_cke_pd_ctrl (
        .clk(clk), .rst_n(rst_n), .pd_en(pd_en), .cs_mode(cs_mode),
        .cs_pending(cs_pending), .cs_closed(cs_closed),
        .idle_limit(idle_limit), .exit_lat(exit_lat),
        .cke(cke), .pd_state(pd_state), .ready(ready)
    );

    // Behavioural reference: pin levels, idle run lengths, exit countdowns.
    bit m_up[2];
    int m_run[2];
    int m_wait[2];
    bit m_mode;

    function automatic bit half_idle(int first, int last);
        bit r = 1'b1;
        for (int i = first; i <= last; i++)
            if (cs_pending[i] || !cs_closed[i]) r = 1'b0;
        return r;
    endfunction

    always @(posedge clk) begin : ref_model
        bit both, restart, q;
        if (!rst_n) begin
            for (int g = 0; g < 2; g++) begin
                m_up[g] = 1'b1; m_run[g] = 0; m_wait[g] = 0;
            end
            m_mode = 1'b0;
        end else begin
            both    = m_up[0] && m_up[1];
            restart = both && (cs_mode != m_mode);
            for (int g = 0; g < 2; g++) begin
                if (m_mode) q = pd_en && half_idle(2*g, 2*g+1);
                else        q = pd_en && half_idle(0, NUM_CS-1);
                if (m_up[g]) begin
                    if (!restart && q && m_run[g] >= int'(idle_limit)) begin
                        m_up[g] = 1'b0; m_run[g] = 0; m_wait[g] = 0;
                    end else begin
                        m_run[g] = (!restart && q) ? m_run[g] + 1 : 0;
                        if (m_wait[g] > 0) m_wait[g] = m_wait[g] - 1;
                    end
                end else if (!q) begin
                    m_up[g] = 1'b1; m_run[g] = 0; m_wait[g] = int'(exit_lat);
                end
            end
            if (both) m_mode = cs_mode;
        end
    end

    task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model on each falling edge.
    task automatic run(int n);
        repeat (n) begin
            logic [1:0] ec, er;
            @(negedge clk);
            ec = {m_up[1], m_up[0]};
            er = {m_up[1] && m_wait[1] == 0, m_up[0] && m_wait[0] == 0};
            chk("R5/R6 cke", cke, ec);
            chk("R8 pd_state", pd_state, ~ec);
            chk("R7 ready", ready, er);
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        run(3);
        chk("R1 cke", cke, 2'b11);
        chk("R1 pd_state", pd_state, 2'b00);
        chk("R1 ready", ready, 2'b11);
        rst_n = 1'b1; pd_en = 1'b1; idle_limit = 8'd3; exit_lat = 4'd2;
        run(4);
        // Whole channel quiet: both pins drop together.
        cs_pending = '0; cs_closed = '1;
        run(8);
        chk("R4 both down", cke, 2'b00);
        // Work on chip select 3 wakes both pins in channel mode.
        cs_pending = 4'b1000;
        run(1);
        chk("R6 wake", cke, 2'b11);
        chk("R7 exit wait", ready, 2'b00);
        run(3);
        chk("R7 ready", ready, 2'b11);
        // Open page blocks entry.
        cs_pending = '0; cs_closed = 4'b1101;
        run(10);
        chk("R3 page open", cke, 2'b11);
        // Enable clear blocks entry.
        cs_closed = '1; pd_en = 1'b0;
        run(10);
        chk("R3 disabled", cke, 2'b11);
        // Switch to chip-select mode; only the upper half busy.
        cs_mode = 1'b1; cs_pending = 4'b0100;
        run(2);
        pd_en = 1'b1;
        run(8);
        chk("R2 lower half down", cke, 2'b10);
        // Mode request while a pin is low is ignored: pin 0 stays down.
        cs_mode = 1'b0;
        run(8);
        chk("R9 mode held", cke, 2'b10);
        // Upper-half work ending drops pin 1 too; lower stays down.
        cs_pending = '0;
        run(8);
        chk("R2 both halves down", cke, 2'b00);
        // Wake only lower half in chip-select mode.
        cs_pending = 4'b0001;
        run(4);
        chk("R2 lower wake only", cke, 2'b01);
        // Immediate entry and zero exit latency.
        idle_limit = 8'd0; exit_lat = 4'd0; cs_pending = '0;
        run(1);
        chk("R5 zero limit", cke, 2'b00);
        cs_pending = 4'b1111;
        run(1);
        chk("R7 zero latency", ready, 2'b11);
        // R10: lower half counts in cs mode, then mode change restarts both.
        idle_limit = 8'd5; cs_mode = 1'b1;
        run(2);
        cs_pending = 4'b1100;
        run(3);
        cs_mode = 1'b0; cs_pending = '0;
        for (int k = 0; k < 10; k++) begin
            run(1);
            chk("R10 pins equal", {1'b0, cke[0]}, {1'b0, cke[1]});
        end
        chk("R10 both down", cke, 2'b00);
        rst_n = 1'b0;
        run(2);
        chk("R1 reset again", cke, 2'b11);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule